// File: doc/BRIEF.md
# Port Group Table Entry Allocator

This block keeps track of which entries of a port-group mask table are in use. Other logic sends it commands over a valid/ready port. A command can claim a free entry in one of two pools, return an entry, or add a holder to an entry that is already claimed. Each accepted command produces a one-cycle response that carries the index involved and a fail flag. The block holds no mask contents and does no forwarding lookup; it only does the occupancy and reference bookkeeping.

The low part of the table is fixed for per-port destination, flood and CPU-forwarding masks and is never handed out. Above it, a group pool (default 72..111) serves multicast groups. Inside the group pool sits an aggregation window (default 96..103) that the allocator never grants. Above the group pool, a profile pool (default 112..127) serves virtualization profiles. In each pool the search starts a fixed offset (default 8) above the pool base. It examines one entry per cycle, moving upward, and stops at the first free entry or at the end of the pool.

Each entry holds a small saturating holder count, and the entry is free when its count is zero. A claim sets the count to one. A reference adds one. A return subtracts one, so the entry becomes free again only when its last holder has returned it.

Top module: `pgt_alloc`

## Requirements
- R1: After reset, cmd_ready is 1, resp_valid is 0, err_sticky is 0 and every entry is free, so the first group claim grants index 80.
- R2: A claim (cmd_op 2'b00) with cmd_region 0 grants the lowest free index in 80..111, never an index in the aggregation window 96..103.
- R3: A claim with cmd_region 1 grants the lowest free index in 120..127.
- R4: No successful claim ever returns an index below 80, so the fixed entries 0..71 and the pool-base entries 72..79 are never granted.
- R5: When the chosen pool has no free entry, the claim response has resp_fail 1 and no entry changes state.
- R6: A reference (cmd_op 2'b10, and 2'b11 acts the same) on a claimed entry adds a holder. A return (cmd_op 2'b01) removes one. The entry stays claimed until the number of returns equals the number of claims plus references.
- R7: A return or a reference that names a free entry, an entry below 72 or an entry in the aggregation window responds with resp_fail 1, resp_idx equal to cmd_idx, and err_sticky set. No entry changes state.
- R8: Once set, err_sticky stays 1 until reset.
- R9: A return or reference answers on the first edge after the accepting edge. A claim answers k+1 edges after acceptance, where k is the number of entries examined from the pool start through the granted index or the pool end. cmd_ready is 0 and resp_valid is 0 while a search is in progress.
- R10: A reference on an entry whose count is at its maximum (7 with 3-bit counts) responds with resp_fail 1. The count does not change and err_sticky is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command (no search in progress) |
| cmd_op | input | 2 | 00 claim, 01 return, 10/11 reference |
| cmd_region | input | 1 | Pool for a claim: 0 group pool, 1 profile pool |
| cmd_idx | input | 7 | Entry index for return or reference |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_op | output | 2 | Operation code of the command being answered |
| resp_fail | output | 1 | Command failed or was ignored |
| resp_idx | output | 7 | Granted or addressed index (0 when a claim fails) |
| err_sticky | output | 1 | Set by an invalid return or reference; cleared by reset |

## Verification
The checker tests the following on every cycle: a granted index never falls below the search start and never lands in the aggregation window; the error flag never clears once set; the flag rises only together with a failing response; returns and references are always answered on the next edge; and no response appears while a search holds cmd_ready low. Other properties need stimulus sequences. The lowest-free choice, the exact search latency and the holder counting over several references, saturation and pool exhaustion can only be shown by the bench's scenarios, which compare each response against indices and latencies it predicts.

// File: rtl/pgt_pkg.sv
package pgt_pkg;

    typedef enum logic [1:0] {
        K_CLAIM = 2'd0,
        K_DROP  = 2'd1,
        K_SHARE = 2'd2
    } pgt_kind_e;

    typedef struct packed {
        pgt_kind_e kind;
        logic      bad;
        logic      sat;
    } pgt_cmd_t;

    function automatic pgt_kind_e pgt_decode(input logic [1:0] op);
        if (op[1])      return K_SHARE;
        else if (op[0]) return K_DROP;
        else            return K_CLAIM;
    endfunction

    function automatic logic pgt_in_span(input int unsigned v,
                                         input int unsigned lo,
                                         input int unsigned hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/pgt_refstore.sv
module pgt_refstore #(
    parameter int N_ENTRIES = 128,
    parameter int IDX_W     = 7,
    parameter int CNT_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [CNT_W-1:0] rd_a_cnt,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [CNT_W-1:0] rd_b_cnt,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] wr_cnt
);

    logic [CNT_W-1:0] cnt_q [N_ENTRIES];

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                cnt_q[g] <= '0;
            else if (wr_en && (int'(wr_idx) == g))
                cnt_q[g] <= wr_cnt;
        end
    end

    assign rd_a_cnt = cnt_q[rd_a_idx];
    assign rd_b_cnt = cnt_q[rd_b_idx];

endmodule

// File: rtl/pgt_scan.sv
module pgt_scan #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] start_ptr,
    input  logic [IDX_W-1:0] end_ptr,
    input  logic             hit,
    output logic             busy,
    output logic [IDX_W-1:0] ptr,
    output logic             at_end
);

    logic [IDX_W-1:0] last_q;

    assign at_end = (ptr == last_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            ptr    <= '0;
            last_q <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            ptr    <= start_ptr;
            last_q <= end_ptr;
        end else if (busy) begin
            if (hit || at_end)
                busy <= 1'b0;
            else
                ptr <= ptr + IDX_W'(1);
        end
    end

endmodule

// File: rtl/pgt_alloc.sv
module pgt_alloc
    import pgt_pkg::*;
#(
    parameter int N_ENTRIES  = 128,
    parameter int RESV_LO    = 72,
    parameter int SEARCH_OFS = 8,
    parameter int GRP_END    = 111,
    parameter int AGG_LO     = 96,
    parameter int AGG_HI     = 103,
    parameter int CNT_W      = 3,
    localparam int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [1:0]       cmd_op,
    input  logic             cmd_region,
    input  logic [IDX_W-1:0] cmd_idx,
    output logic             resp_valid,
    output logic [1:0]       resp_op,
    output logic             resp_fail,
    output logic [IDX_W-1:0] resp_idx,
    output logic             err_sticky
);

    localparam int GRP_START = RESV_LO + SEARCH_OFS;
    localparam int PRF_START = GRP_END + 1 + SEARCH_OFS;
    localparam int PRF_END   = N_ENTRIES - 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             busy, at_end, hit, accept;
    logic [IDX_W-1:0] ptr;
    logic [CNT_W-1:0] cnt_scan, cnt_cmd;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [CNT_W-1:0] wr_cnt;
    pgt_cmd_t         cmd;

    assign cmd_ready = !busy;
    assign accept    = cmd_valid && cmd_ready;

    always_comb begin
        cmd.kind = pgt_decode(cmd_op);
        cmd.bad  = (int'(cmd_idx) < RESV_LO)
                || pgt_in_span(int'(cmd_idx), AGG_LO, AGG_HI)
                || (cnt_cmd == '0);
        cmd.sat  = (cnt_cmd == CNT_MAX);
    end

    assign hit = busy && (cnt_scan == '0)
              && !pgt_in_span(int'(ptr), AGG_LO, AGG_HI);

    pgt_scan #(.IDX_W(IDX_W)) u_scan (
        .clk       (clk),
        .rst       (rst),
        .start     (accept && cmd.kind == K_CLAIM),
        .start_ptr (cmd_region ? IDX_W'(PRF_START) : IDX_W'(GRP_START)),
        .end_ptr   (cmd_region ? IDX_W'(PRF_END)   : IDX_W'(GRP_END)),
        .hit       (hit),
        .busy      (busy),
        .ptr       (ptr),
        .at_end    (at_end)
    );

    pgt_refstore #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (ptr),
        .rd_a_cnt (cnt_scan),
        .rd_b_idx (cmd_idx),
        .rd_b_cnt (cnt_cmd),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_cnt   (wr_cnt)
    );

    always_comb begin
        wr_en  = 1'b0;
        wr_idx = cmd_idx;
        wr_cnt = cnt_cmd;
        if (hit) begin
            wr_en  = 1'b1;
            wr_idx = ptr;
            wr_cnt = CNT_W'(1);
        end else if (accept && cmd.kind == K_DROP && !cmd.bad) begin
            wr_en  = 1'b1;
            wr_cnt = cnt_cmd - CNT_W'(1);
        end else if (accept && cmd.kind == K_SHARE && !cmd.bad && !cmd.sat) begin
            wr_en  = 1'b1;
            wr_cnt = cnt_cmd + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_op    <= 2'b00;
            resp_fail  <= 1'b0;
            resp_idx   <= '0;
            err_sticky <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            if (busy && (hit || at_end)) begin
                resp_valid <= 1'b1;
                resp_op    <= 2'b00;
                resp_fail  <= !hit;
                resp_idx   <= hit ? ptr : '0;
            end else if (accept && cmd.kind != K_CLAIM) begin
                resp_valid <= 1'b1;
                resp_op    <= cmd_op;
                resp_fail  <= cmd.bad || (cmd.kind == K_SHARE && cmd.sat);
                resp_idx   <= cmd_idx;
                if (cmd.bad)
                    err_sticky <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pgt_alloc_chk.sv
module pgt_alloc_chk #(
    parameter int IDX_W     = 7,
    parameter int GRP_START = 80,
    parameter int AGG_LO    = 96,
    parameter int AGG_HI    = 103
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [1:0]       cmd_op,
    input logic             resp_valid,
    input logic [1:0]       resp_op,
    input logic             resp_fail,
    input logic [IDX_W-1:0] resp_idx,
    input logic             err_sticky
);

    logic grant;
    assign grant = resp_valid && resp_op == 2'b00 && !resp_fail;

    a_r4_grant_above_offset: assert property (@(posedge clk) disable iff (rst)
        grant |-> int'(resp_idx) >= GRP_START);

    a_r2_grant_outside_agg: assert property (@(posedge clk) disable iff (rst)
        grant |-> (int'(resp_idx) < AGG_LO || int'(resp_idx) > AGG_HI));

    a_r8_err_holds: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> err_sticky);

    a_r7_err_with_fail: assert property (@(posedge clk) disable iff (rst)
        $rose(err_sticky) |-> (resp_valid && resp_fail));

    a_r9_quiet_while_busy: assert property (@(posedge clk) disable iff (rst)
        !cmd_ready |-> !resp_valid);

    a_r9_quick_answer: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_op != 2'b00) |=> (resp_valid && resp_op == $past(cmd_op)));

endmodule

bind pgt_alloc pgt_alloc_chk #(
    .IDX_W(IDX_W), .GRP_START(RESV_LO + SEARCH_OFS), .AGG_LO(AGG_LO), .AGG_HI(AGG_HI)
) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .resp_valid(resp_valid), .resp_op(resp_op), .resp_fail(resp_fail),
    .resp_idx(resp_idx), .err_sticky(err_sticky)
);

// File: tb/pgt_alloc_test.sv
`timescale 1ns/1ps
module pgt_alloc_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [1:0] cmd_op = 2'b00;
    logic       cmd_region = 1'b0;
    logic [6:0] cmd_idx = '0;
    logic       resp_valid;
    logic [1:0] resp_op;
    logic       resp_fail;
    logic [6:0] resp_idx;
    logic       err_sticky;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pgt_alloc uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_region(cmd_region), .cmd_idx(cmd_idx),
        .resp_valid(resp_valid), .resp_op(resp_op), .resp_fail(resp_fail),
        .resp_idx(resp_idx), .err_sticky(err_sticky)
    );

    typedef struct packed {
        logic [1:0] op;
        logic       region;
        logic [6:0] idx;
        logic       efail;
        logic [6:0] eidx;
        logic [7:0] elat;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{2'b00, 1'b0, 7'd0,  1'b0, 7'd80,  8'd2},
        '{2'b00, 1'b0, 7'd0,  1'b0, 7'd81,  8'd3},
        '{2'b00, 1'b1, 7'd0,  1'b0, 7'd120, 8'd2},
        '{2'b01, 1'b0, 7'd80, 1'b0, 7'd80,  8'd1},
        '{2'b00, 1'b0, 7'd0,  1'b0, 7'd80,  8'd2},
        '{2'b10, 1'b0, 7'd81, 1'b0, 7'd81,  8'd1},
        '{2'b01, 1'b0, 7'd81, 1'b0, 7'd81,  8'd1},
        '{2'b00, 1'b0, 7'd0,  1'b0, 7'd82,  8'd4},
        '{2'b01, 1'b0, 7'd81, 1'b0, 7'd81,  8'd1},
        '{2'b00, 1'b0, 7'd0,  1'b0, 7'd81,  8'd3}
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic region, input logic [6:0] idx,
                          output logic fail, output logic [6:0] ridx, output int lat);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_op     = op;
        cmd_region = region;
        cmd_idx    = idx;
        @(posedge clk);
        lat = 0;
        fail = 1'b1;
        ridx = '0;
        for (int w = 0; w < 300; w++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            lat++;
            if (resp_valid) begin
                fail = resp_fail;
                ridx = resp_idx;
                break;
            end
        end
    endtask

    task automatic expect_cmd(input logic [1:0] op, input logic region, input logic [6:0] idx,
                              input logic efail, input logic [6:0] eidx, input int elat,
                              input string req);
        logic f;
        logic [6:0] r;
        int l;
        do_cmd(op, region, idx, f, r, l);
        check(f == efail, {req, " fail"}, int'(f), int'(efail));
        if (!efail || op != 2'b00)
            check(r == eidx, {req, " index"}, int'(r), int'(eidx));
        if (elat > 0)
            check(l == elat, {req, " latency"}, l, elat);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(cmd_ready == 1'b1, "R1 ready", int'(cmd_ready), 1);
        check(resp_valid == 1'b0, "R1 resp_valid", int'(resp_valid), 0);
        check(err_sticky == 1'b0, "R1 err", int'(err_sticky), 0);

        // R2 R3 R6 R9 table walk
        foreach (VEC[i])
            expect_cmd(VEC[i].op, VEC[i].region, VEC[i].idx, VEC[i].efail,
                       VEC[i].eidx, int'(VEC[i].elat), "R2/R3/R6/R9 vector");

        // R10 saturation on entry 82 (count 1 -> 7, then one more fails)
        for (int k = 0; k < 6; k++)
            expect_cmd(2'b10, 1'b0, 7'd82, 1'b0, 7'd82, 1, "R6 share");
        expect_cmd(2'b11, 1'b0, 7'd82, 1'b1, 7'd82, 1, "R10 saturated share");
        check(err_sticky == 1'b0, "R10 no err", int'(err_sticky), 0);
        // R6 seven returns needed before 82 is free again
        for (int k = 0; k < 6; k++)
            expect_cmd(2'b01, 1'b0, 7'd82, 1'b0, 7'd82, 1, "R6 return");
        expect_cmd(2'b00, 1'b0, 7'd0, 1'b0, 7'd83, 5, "R6 still held");
        expect_cmd(2'b01, 1'b0, 7'd82, 1'b0, 7'd82, 1, "R6 last return");
        expect_cmd(2'b00, 1'b0, 7'd0, 1'b0, 7'd82, 4, "R6 reclaimed");

        // R2 R4 fill group pool, skipping aggregation window
        for (int e = 84; e <= 111; e++) begin
            if (e < 96 || e > 103)
                expect_cmd(2'b00, 1'b0, 7'd0, 1'b0, 7'(e), e - 80 + 2, "R2 fill");
        end
        // R5 exhausted group pool
        expect_cmd(2'b00, 1'b0, 7'd0, 1'b1, 7'd0, 33, "R5 group exhausted");
        // R3 fill profile pool
        for (int e = 121; e <= 127; e++)
            expect_cmd(2'b00, 1'b1, 7'd0, 1'b0, 7'(e), e - 120 + 2, "R3 fill");
        expect_cmd(2'b00, 1'b1, 7'd0, 1'b1, 7'd0, 9, "R5 profile exhausted");

        // R7 invalid returns and references
        check(err_sticky == 1'b0, "R7 err before", int'(err_sticky), 0);
        expect_cmd(2'b01, 1'b0, 7'd5, 1'b1, 7'd5, 1, "R7 return fixed entry");
        check(err_sticky == 1'b1, "R7 err set", int'(err_sticky), 1);
        expect_cmd(2'b01, 1'b0, 7'd100, 1'b1, 7'd100, 1, "R7 return agg entry");
        expect_cmd(2'b10, 1'b0, 7'd75, 1'b1, 7'd75, 1, "R7 share free entry");
        expect_cmd(2'b01, 1'b0, 7'd121, 1'b0, 7'd121, 1, "R7 valid return");
        expect_cmd(2'b01, 1'b0, 7'd121, 1'b1, 7'd121, 1, "R7 double return");
        expect_cmd(2'b00, 1'b1, 7'd0, 1'b0, 7'd121, 3, "R7 no state change");
        expect_cmd(2'b00, 1'b0, 7'd0, 1'b1, 7'd0, 33, "R5 pool untouched");
        // R8 sticky
        repeat (5) @(negedge clk);
        check(err_sticky == 1'b1, "R8 sticky", int'(err_sticky), 1);

        // R1 reset again
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(err_sticky == 1'b0, "R1 err cleared", int'(err_sticky), 0);
        check(resp_valid == 1'b0, "R1 no resp", int'(resp_valid), 0);
        check(cmd_ready == 1'b1, "R1 ready after reset", int'(cmd_ready), 1);
        expect_cmd(2'b00, 1'b0, 7'd0, 1'b0, 7'd80, 2, "R1 all free");
        expect_cmd(2'b00, 1'b1, 7'd0, 1'b0, 7'd120, 2, "R1 profile free");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule